// File: doc/BRIEF.md
# Chained Transmit Descriptor DMA

This engine feeds an Ethernet transmitter from memory. It follows a linked list of four-word descriptors. For each descriptor it checks the ownership bit and reads the byte count and buffer pointer. It then streams the buffer one byte at a time into a transmit FIFO, flagging the first and last byte of each frame. When a frame ends, it waits for the transmitter's completion report. It then writes the result back into the descriptor: status in word 0, and optionally a 64-bit timestamp in words 2 and 3. Clearing the ownership bit in word 0 hands the descriptor back to software.

The engine comes out of reset suspended. A poll-demand strobe wakes it. On the first strobe it loads the list head from `base_addr`; on every later strobe it re-reads the descriptor it stopped at. It suspends again when it meets a descriptor that software still owns, or after it closes a frame that reported an underflow. Three sticky flags record transmit-done, descriptor-unavailable and underflow. Software clears them by writing ones to the clear input. An interrupt output and an abnormal-summary output are derived from the flags.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is suspended, makes no memory request, pushes no bytes and holds all flags at 0. The first poll strobe loads the list head from `base_addr`. Later changes to `base_addr` have no effect.
- R2: A fetched word 0 with bit 31 = 0 stops the walk without moving any data. The engine suspends and sets flag bit 1 (descriptor unavailable).
- R3: A poll strobe while suspended resumes the walk by re-reading the descriptor at the current pointer.
- R4: A descriptor moves word1[12:0] bytes, starting at the byte address in word 2, in ascending address order. Memory words are little-endian, so byte lane k holds address 4n+k. Any start alignment is accepted. Word1[28:16] is ignored.
- R5: `fifo_sof` accompanies the first byte of a descriptor with word0 bit 28 set. `fifo_eof` accompanies the last byte of a descriptor with word0 bit 29 set. The next descriptor address is always taken from word 3, so one frame may span several descriptors.
- R6: Closing a descriptor writes word 0 with bits 31..18 zero. A descriptor that does not end a frame is closed with word 0 = 0.
- R7: If bit 24 is set in a frame's last descriptor, that descriptor's word 2 receives the low 32 timestamp bits and word 3 the high 32, and word0 bit 17 is set. Otherwise words 2 and 3 are left unchanged.
- R8: The last descriptor of a frame is closed with word0[16:0] = the reported status. On an underflow report, bits 1 and 15 are also set, flag bit 2 is set, `abnormal` rises, and the engine suspends with its pointer on the following descriptor.
- R9: A frame without underflow whose last descriptor has bit 30 set sets flag bit 0 (transmit done) when it closes.
- R10: Flags stay set until a 1 is written to the matching `flag_clr` bit. `irq` is the OR of all flags, and `abnormal` reflects flag bit 2 only.
- R11: A memory request holds its address, direction and data until `mem_ready`. A FIFO push holds its byte and markers until `fifo_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_addr | input | 32 | Byte address of the first descriptor |
| poll | input | 1 | Poll-demand strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| mem_ready | input | 1 | Memory accepts/completes the access |
| fifo_valid | output | 1 | Byte offered to the FIFO |
| fifo_ready | input | 1 | FIFO takes the byte |
| fifo_data | output | 8 | Byte value |
| fifo_sof | output | 1 | First byte of a frame |
| fifo_eof | output | 1 | Last byte of a frame |
| done_valid | input | 1 | Completion report strobe |
| done_status | input | 17 | Completion status |
| done_underflow | input | 1 | Frame aborted by underflow |
| done_ts | input | 64 | Captured timestamp |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| flags | output | 3 | Sticky flags: bit0 done, bit1 unavailable, bit2 underflow |
| abnormal | output | 1 | Abnormal summary |
| irq | output | 1 | Interrupt request |
| suspended | output | 1 | Engine is in the suspend state |

## Verification
The hardest case to reach is the underflow suspend. The underflow suspend leaves the pointer on the next descriptor, and telling it apart from an ownership suspend needs a later descriptor that is valid and observable. The bench builds that chain in memory and answers the frame with an underflow report. It then checks that the following descriptor is still untouched, that only flag bit 2 is set, and that the next poll delivers that following frame's byte. A sweep of 36 single-descriptor frames covers every length from 1 to 9 at every start alignment. The memory and FIFO ready lines stall in two different periodic patterns, and each frame gets its own completion values.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W    = 32;
  localparam int STS_W     = 17;
  localparam int CNT_W     = 13;
  localparam int TS_W      = 2 * WORD_W;
  localparam int FLAG_N    = 3;
  localparam int BYTE_W    = 8;
  localparam int LANE_W    = $clog2(WORD_W / BYTE_W);

  localparam int OWN_BIT   = 31;
  localparam int IC_BIT    = 30;
  localparam int LS_BIT    = 29;
  localparam int FS_BIT    = 28;
  localparam int TSE_BIT   = 24;
  localparam int TSS_BIT   = 17;
  localparam int UNF_BIT   = 1;
  localparam int ERR_BIT   = 15;

  localparam int FLG_TXI   = 0;
  localparam int FLG_TBU   = 1;
  localparam int FLG_UNF   = 2;
  localparam logic [FLAG_N-1:0] ABN_MASK = FLAG_N'(1) << FLG_UNF;

  localparam logic [WORD_W-1:0] W1_OFS = WORD_W'(4);
  localparam logic [WORD_W-1:0] W2_OFS = WORD_W'(8);
  localparam logic [WORD_W-1:0] W3_OFS = WORD_W'(12);

  typedef enum logic [3:0] {
    S_SUSP, S_RD0, S_RD1, S_RD2, S_RD3, S_BRD, S_PUSH,
    S_WAIT, S_WB2, S_WB3, S_WB0
  } seq_state_e;

  typedef struct packed {
    logic ic;
    logic ls;
    logic fs;
    logic tse;
  } desc_ctl_t;

  // Closing value of word 0: status, error marks, timestamp mark, owner cleared
  function automatic logic [WORD_W-1:0] close_word(input logic [STS_W-1:0] st,
                                                   input logic unf,
                                                   input logic tss);
    logic [WORD_W-1:0] w;
    w = WORD_W'(st);
    if (unf) begin
      w[UNF_BIT] = 1'b1;
      w[ERR_BIT] = 1'b1;
    end
    w[TSS_BIT] = tss;
    return w;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic [LANE_W-1:0] k);
    return w[k*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/txd_lane.sv
module txd_lane
  import txd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  input  logic              first_pend,
  input  logic              last_desc,
  input  logic [CNT_W-1:0]  remain,
  output logic [BYTE_W-1:0] data,
  output logic              sof,
  output logic              eof
);
  assign data = lane_pick(word, lane);
  assign sof  = first_pend;
  assign eof  = last_desc && (remain == CNT_W'(1));
endmodule

// File: rtl/txd_flags.sv
module txd_flags
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set,
  input  logic [FLAG_N-1:0] clr,
  output logic [FLAG_N-1:0] flags,
  output logic              abnormal,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assign abnormal = |(flags & ABN_MASK);
  assign irq      = |flags;
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base_addr,
  input  logic              poll,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              push_req,
  input  logic              push_ack,
  output logic [WORD_W-1:0] lane_word,
  output logic [LANE_W-1:0] lane_sel,
  output logic              first_pend,
  output logic              last_desc,
  output logic [CNT_W-1:0]  remain,
  input  logic              done_valid,
  input  logic [STS_W-1:0]  done_status,
  input  logic              done_underflow,
  input  logic [TS_W-1:0]   done_ts,
  output logic [FLAG_N-1:0] flag_set,
  output logic              suspended,
  output logic              evt_close,
  output logic              evt_own_miss,
  output logic              evt_resume
);
  seq_state_e        state;
  logic              started;
  logic [WORD_W-1:0] cur, nxt, bptr, wbuf;
  desc_ctl_t         ctl;
  logic [CNT_W-1:0]  cnt;
  logic [STS_W-1:0]  cap_st;
  logic              cap_unf;
  logic [TS_W-1:0]   cap_ts;
  logic              first_q;
  logic              hs;
  logic              ts_wr;

  assign hs    = mem_req && mem_ready;
  assign ts_wr = ctl.tse && ctl.ls;

  // Memory port driven purely from state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (state)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin mem_req = 1'b1; mem_addr = cur + W1_OFS; end
      S_RD2: begin mem_req = 1'b1; mem_addr = cur + W2_OFS; end
      S_RD3: begin mem_req = 1'b1; mem_addr = cur + W3_OFS; end
      S_BRD: begin mem_req = 1'b1; mem_addr = {bptr[WORD_W-1:LANE_W], LANE_W'(0)}; end
      S_WB2: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + W2_OFS;
        mem_wdata = cap_ts[WORD_W-1:0];
      end
      S_WB3: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + W3_OFS;
        mem_wdata = cap_ts[TS_W-1:WORD_W];
      end
      S_WB0: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = close_word(cap_st, cap_unf, ts_wr);
      end
      default: ;
    endcase
  end

  assign push_req   = (state == S_PUSH);
  assign lane_word  = wbuf;
  assign lane_sel   = bptr[LANE_W-1:0];
  assign first_pend = first_q;
  assign last_desc  = ctl.ls;
  assign remain     = cnt;

  assign suspended    = (state == S_SUSP);
  assign evt_close    = (state == S_WB0) && hs;
  assign evt_own_miss = (state == S_RD0) && hs && !mem_rdata[OWN_BIT];
  assign evt_resume   = (state == S_SUSP) && poll;

  always_comb begin
    flag_set = '0;
    flag_set[FLG_TBU] = evt_own_miss;
    if (evt_close && ctl.ls) begin
      flag_set[FLG_UNF] = cap_unf;
      flag_set[FLG_TXI] = !cap_unf && ctl.ic;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_SUSP;
      started <= 1'b0;
      cur     <= '0;
      nxt     <= '0;
      bptr    <= '0;
      wbuf    <= '0;
      ctl     <= '0;
      cnt     <= '0;
      cap_st  <= '0;
      cap_unf <= 1'b0;
      cap_ts  <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (state)
        S_SUSP: if (poll) begin
          if (!started) cur <= base_addr;
          started <= 1'b1;
          state   <= S_RD0;
        end
        S_RD0: if (hs) begin
          if (!mem_rdata[OWN_BIT]) begin
            state <= S_SUSP;
          end else begin
            ctl.ic  <= mem_rdata[IC_BIT];
            ctl.ls  <= mem_rdata[LS_BIT];
            ctl.fs  <= mem_rdata[FS_BIT];
            ctl.tse <= mem_rdata[TSE_BIT];
            first_q <= mem_rdata[FS_BIT];
            cap_st  <= '0;
            cap_unf <= 1'b0;
            state   <= S_RD1;
          end
        end
        S_RD1: if (hs) begin
          cnt   <= mem_rdata[CNT_W-1:0];
          state <= S_RD2;
        end
        S_RD2: if (hs) begin
          bptr  <= mem_rdata;
          state <= S_RD3;
        end
        S_RD3: if (hs) begin
          nxt <= mem_rdata;
          if (cnt != '0)   state <= S_BRD;
          else if (ctl.ls) state <= S_WAIT;
          else             state <= S_WB0;
        end
        S_BRD: if (hs) begin
          wbuf  <= mem_rdata;
          state <= S_PUSH;
        end
        S_PUSH: if (push_ack) begin
          cnt     <= cnt - CNT_W'(1);
          bptr    <= bptr + WORD_W'(1);
          first_q <= 1'b0;
          if (cnt == CNT_W'(1))             state <= ctl.ls ? S_WAIT : S_WB0;
          else if (&bptr[LANE_W-1:0])       state <= S_BRD;
        end
        S_WAIT: if (done_valid) begin
          cap_st  <= done_status;
          cap_unf <= done_underflow;
          cap_ts  <= done_ts;
          state   <= ts_wr ? S_WB2 : S_WB0;
        end
        S_WB2: if (hs) state <= S_WB3;
        S_WB3: if (hs) state <= S_WB0;
        S_WB0: if (hs) begin
          cur   <= nxt;
          state <= (ctl.ls && cap_unf) ? S_SUSP : S_RD0;
        end
        default: state <= S_SUSP;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base_addr,
  input  logic              poll,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_sof,
  output logic              fifo_eof,
  input  logic              done_valid,
  input  logic [STS_W-1:0]  done_status,
  input  logic              done_underflow,
  input  logic [TS_W-1:0]   done_ts,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic [FLAG_N-1:0] flags,
  output logic              abnormal,
  output logic              irq,
  output logic              suspended
);
  logic [WORD_W-1:0] lane_word;
  logic [LANE_W-1:0] lane_sel;
  logic              first_pend, last_desc;
  logic [CNT_W-1:0]  remain;
  logic [FLAG_N-1:0] flag_set;
  logic              evt_close, evt_own_miss, evt_resume;

  txd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .push_req(fifo_valid), .push_ack(fifo_ready),
    .lane_word(lane_word), .lane_sel(lane_sel), .first_pend(first_pend),
    .last_desc(last_desc), .remain(remain),
    .done_valid(done_valid), .done_status(done_status),
    .done_underflow(done_underflow), .done_ts(done_ts),
    .flag_set(flag_set), .suspended(suspended), .evt_close(evt_close),
    .evt_own_miss(evt_own_miss), .evt_resume(evt_resume)
  );

  txd_lane u_lane (
    .word(lane_word), .lane(lane_sel), .first_pend(first_pend),
    .last_desc(last_desc), .remain(remain),
    .data(fifo_data), .sof(fifo_sof), .eof(fifo_eof)
  );

  txd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
    .flags(flags), .abnormal(abnormal), .irq(irq)
  );
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk
  import txd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              fifo_valid,
  input logic              fifo_ready,
  input logic [BYTE_W-1:0] fifo_data,
  input logic              fifo_sof,
  input logic              fifo_eof,
  input logic              suspended,
  input logic [FLAG_N-1:0] flags,
  input logic [FLAG_N-1:0] flag_clr,
  input logic              evt_close,
  input logic              evt_own_miss,
  input logic              evt_resume
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data) && $stable(fifo_sof) && $stable(fifo_eof));

  // R1
  quiet_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req && !fifo_valid);

  // R6
  close_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_close |-> mem_we && (mem_wdata[WORD_W-1:TSS_BIT+1] == '0));

  // R2
  own_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_own_miss |=> suspended && flags[FLG_TBU]);

  // R3
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resume |=> !suspended && mem_req && !mem_we);

  // R10
  genvar i;
  for (i = 0; i < FLAG_N; i++) begin : g_sticky
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !flag_clr[i] |=> flags[i]);
  end
endmodule

bind txdesc_dma txdesc_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
  .fifo_sof(fifo_sof), .fifo_eof(fifo_eof), .suspended(suspended),
  .flags(flags), .flag_clr(flag_clr), .evt_close(evt_close),
  .evt_own_miss(evt_own_miss), .evt_resume(evt_resume)
);

// File: tb/txdesc_dma_bench.sv
`timescale 1ns/1ps
module txdesc_dma_bench;
  localparam logic [31:0] D_OWN = 32'h8000_0000;
  localparam logic [31:0] D_IC  = 32'h4000_0000;
  localparam logic [31:0] D_LS  = 32'h2000_0000;
  localparam logic [31:0] D_FS  = 32'h1000_0000;
  localparam logic [31:0] D_TSE = 32'h0100_0000;
  localparam logic [31:0] B_TSS = 32'h0002_0000;
  localparam logic [31:0] B_UNF = 32'h0000_8002;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, poll, mem_req, mem_we, mem_ready;
  logic [31:0] base_addr, mem_addr, mem_wdata, mem_rdata;
  logic        fifo_valid, fifo_ready, fifo_sof, fifo_eof;
  logic [7:0]  fifo_data;
  logic        done_valid, done_underflow;
  logic [16:0] done_status;
  logic [63:0] done_ts;
  logic [2:0]  flag_clr, flags;
  logic        abnormal, irq, suspended;

  txdesc_dma u_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .fifo_sof(fifo_sof), .fifo_eof(fifo_eof), .done_valid(done_valid),
    .done_status(done_status), .done_underflow(done_underflow),
    .done_ts(done_ts), .flag_clr(flag_clr), .flags(flags),
    .abnormal(abnormal), .irq(irq), .suspended(suspended)
  );

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[11:2]];

  logic [7:0]  gb [0:4095];
  logic        gs [0:4095];
  logic        ge [0:4095];
  int          ng = 0;
  logic [16:0] dn_st  [0:63];
  logic        dn_unf [0:63];
  logic [63:0] dn_ts  [0:63];
  int          fidx = 0, dcnt = 0, cyc = 0, nreq = 0;
  int          n_chk = 0, n_fail = 0;
  bit          ended = 1'b0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[a/4] = w0; mem[a/4+1] = w1; mem[a/4+2] = w2; mem[a/4+3] = w3;
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_susp(input string tag);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20000 && !suspended; i++) @(negedge clk);
    if (!suspended) begin
      n_chk++; n_fail++;
      $display("FAIL %s engine never suspended actual=0 expected=1", tag);
    end
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  // memory, FIFO sink and completion responder
  initial begin
    mem_ready = 1'b0; fifo_ready = 1'b0; done_valid = 1'b0;
    done_status = '0; done_underflow = 1'b0; done_ts = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready  = (cyc % 3) != 1;
      fifo_ready = (cyc % 5) != 2;
      done_valid = 1'b0;
      if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) begin
          done_valid = 1'b1;
          done_status = dn_st[fidx];
          done_underflow = dn_unf[fidx];
          done_ts = dn_ts[fidx];
          fidx++;
        end
      end
      if (mem_req) nreq++;
      if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] = mem_wdata;
      if (fifo_valid && fifo_ready) begin
        gb[ng] = fifo_data; gs[ng] = fifo_sof; ge[ng] = fifo_eof;
        ng++;
        if (fifo_eof) dcnt = 3;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sb, p, ln, bf, da;
    logic ok;
    logic [31:0] w0;
    rst_n = 1'b0; poll = 1'b0; flag_clr = 3'b000; base_addr = 32'h0;
    for (int w = 0; w < 1024; w++)
      mem[w] = {pat(32'(4*w+3)), pat(32'(4*w+2)), pat(32'(4*w+1)), pat(32'(4*w))};
    // first chain: two-descriptor frame, then a one-descriptor frame, then CPU-owned
    put_desc(32'h00, D_OWN | D_FS, 32'h1F00_0005, 32'h801, 32'h10);
    put_desc(32'h10, D_OWN | D_LS | D_IC | D_TSE, 32'h3, 32'h9FE, 32'h20);
    put_desc(32'h20, D_OWN | D_FS | D_LS, 32'h1, 32'hA00, 32'h30);
    put_desc(32'h30, 32'h0, 32'h0, 32'hA10, 32'h40);
    dn_st[0] = 17'h000A5; dn_unf[0] = 1'b0; dn_ts[0] = 64'h1111_2222_3333_4444;
    dn_st[1] = 17'h1F0F0; dn_unf[1] = 1'b0; dn_ts[1] = 64'h5555_6666_7777_8888;
    dn_st[2] = 17'h00003; dn_unf[2] = 1'b1; dn_ts[2] = 64'h9999_AAAA_BBBB_CCCC;
    dn_st[3] = 17'h00040; dn_unf[3] = 1'b0; dn_ts[3] = 64'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 reset state, no activity before poll
    check("R1 suspended", 64'(suspended), 64'd1);
    check("R1 no memory request", 64'(nreq), 64'd0);
    check("R1 flags/irq/abnormal", 64'({flags, irq, abnormal, fifo_valid}), 64'd0);

    do_poll();
    wait_susp("R2");
    // R4 R5 R11 byte stream of the first two frames under stalls
    check("R4 R11 byte count", 64'(ng), 64'd9);
    ok = 1'b1;
    for (int i = 0; i < 5; i++) if (gb[i] !== pat(32'(32'h801 + i))) ok = 1'b0;
    for (int i = 0; i < 3; i++) if (gb[5+i] !== pat(32'(32'h9FE + i))) ok = 1'b0;
    if (gb[8] !== pat(32'hA00)) ok = 1'b0;
    check("R4 R11 byte values across descriptors", 64'(ok), 64'd1);
    check("R5 sof pattern", 64'({gs[0],gs[1],gs[4],gs[5],gs[7],gs[8]}), 64'b100001);
    check("R5 eof pattern", 64'({ge[0],ge[4],ge[5],ge[6],ge[7],ge[8]}), 64'b000011);
    check("R6 middle descriptor closed to zero", 64'(mem[0]), 64'd0);
    check("R7 R8 last word0 status+tss", 64'(mem[4]), 64'(32'h000A5 | B_TSS));
    check("R7 timestamp low", 64'(mem[6]), 64'h3333_4444);
    check("R7 timestamp high", 64'(mem[7]), 64'h1111_2222);
    check("R8 status without timestamp", 64'(mem[8]), 64'h1F0F0);
    check("R7 words untouched w2", 64'(mem[10]), 64'hA00);
    check("R7 words untouched w3", 64'(mem[11]), 64'h30);
    check("R2 R9 flags", 64'(flags), 64'b011);
    check("R10 irq", 64'(irq), 64'd1);
    check("R10 abnormal low", 64'(abnormal), 64'd0);
    check("R2 owner-0 descriptor untouched", 64'(mem[12]), 64'd0);

    clear_flags(3'b011);
    check("R10 write-one clear", 64'({flags, irq}), 64'd0);

    // underflow frame followed by a valid frame; base changes must be ignored
    base_addr = 32'h700;
    mem[32'h700/4] = 32'h0;
    put_desc(32'h40, D_OWN | D_FS | D_LS, 32'h1, 32'hA20, 32'h50);
    put_desc(32'h50, 32'h0, 32'h0, 32'h0, 32'h0);
    mem[12] = D_OWN | D_FS | D_LS | D_IC | D_TSE; mem[13] = 32'h2;
    sb = ng;
    do_poll();
    wait_susp("R8");
    check("R3 refetch byte count", 64'(ng - sb), 64'd2);
    check("R3 refetch bytes", 64'({gb[sb], gb[sb+1]}), 64'({pat(32'hA10), pat(32'hA11)}));
    check("R8 underflow word0", 64'(mem[12]), 64'(32'h3 | B_UNF | B_TSS));
    check("R8 ts low written", 64'(mem[14]), 64'hBBBB_CCCC);
    check("R8 R9 flags only underflow", 64'(flags), 64'b100);
    check("R8 abnormal", 64'({abnormal, irq}), 64'b11);
    check("R8 next descriptor not yet touched", 64'(mem[16]), 64'(D_OWN | D_FS | D_LS));

    clear_flags(3'b100);
    check("R10 abnormal cleared", 64'({flags, abnormal, irq}), 64'd0);

    sb = ng;
    do_poll();
    wait_susp("R8");
    check("R8 resumes at following descriptor", 64'(ng - sb), 64'd1);
    check("R1 R8 following byte", 64'(gb[sb]), 64'(pat(32'hA20)));
    check("R9 no-ic frame closed", 64'(mem[16]), 64'h40);
    check("R2 unavailable flag", 64'(flags), 64'b010);

    // sweep: lengths 1..9 at every alignment, single-descriptor frames
    for (int k = 0; k < 36; k++) begin
      ln = k % 9 + 1; bf = 32'h800 + k * 16 + k / 9; da = 32'h50 + k * 16;
      w0 = D_OWN | D_FS | D_LS | ((k % 2) ? D_IC : 32'h0) | ((k % 3 == 0) ? D_TSE : 32'h0);
      put_desc(da, w0, 32'(ln) | 32'h0ABC_0000, 32'(bf), 32'(da + 16));
      dn_st[4+k] = 17'(k * 32'h111 + 1); dn_unf[4+k] = 1'b0;
      dn_ts[4+k] = {32'hC000_0000 + 32'(k), 32'hD000_0000 + 32'(k)};
    end
    put_desc(32'h290, 32'h0, 32'h0, 32'h0, 32'h0);
    clear_flags(3'b111);
    sb = ng;
    do_poll();
    wait_susp("R3");
    p = sb;
    for (int k = 0; k < 36; k++) begin
      ln = k % 9 + 1; bf = 32'h800 + k * 16 + k / 9; da = 32'h50 + k * 16;
      ok = 1'b1;
      for (int i = 0; i < ln; i++) begin
        if (gb[p] !== pat(32'(bf + i)) || gs[p] !== (i == 0) || ge[p] !== (i == ln - 1)) ok = 1'b0;
        p++;
      end
      check($sformatf("R4 R5 sweep frame %0d", k), 64'(ok), 64'd1);
      check($sformatf("R6 R8 sweep word0 %0d", k), 64'(mem[da/4]),
            64'(32'(dn_st[4+k]) | ((k % 3 == 0) ? B_TSS : 32'h0)));
      check($sformatf("R7 sweep word2 %0d", k), 64'(mem[da/4+2]),
            (k % 3 == 0) ? 64'(32'hD000_0000 + 32'(k)) : 64'(bf));
    end
    check("R4 sweep total bytes", 64'(p - sb), 64'(ng - sb));
    check("R9 R2 sweep flags", 64'(flags), 64'b011);

    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule